// File: doc/BRIEF.md
# I2C Register-Read Sequencer

This block is an I2C bus master that fetches a single byte from a register of a slave with one combined transaction. A single command supplies the 7-bit slave address and the 8-bit register index. The engine then performs the whole exchange without further help:

- a start condition;
- the address with the write direction, followed by the register index;
- a repeated start;
- the address again with the read direction;
- eight data bits clocked in from the slave;
- a master acknowledge and a stop condition.

The result comes back with a one-cycle completion pulse and an acknowledge-error flag.

SCL is driven directly. SDA is open-drain: the block only ever pulls the line low or releases it, and it reads the wired line back through a separate input. Every SCL low or high phase lasts `PHASE_CLKS` system clocks. The line is sampled in the middle of an SCL high phase. A missing acknowledge from the slave at any of the three acknowledge slots makes the engine abandon the transfer and go straight to the stop condition.

Top module: `i2c_ptr_read_master`

## Requirements
- R1: After reset, and whenever no transfer runs: `busy`=0, `scl_o`=1, `sda_oe`=0 (SDA released), `done`=0. After reset `ack_err`=0 and `rd_data`=0.
- R2: A command is taken only in an idle cycle with `cmd_valid`=1. `busy` goes high at the next clock edge. `cmd_valid` and the command fields have no effect on the bus while `busy`=1.
- R3: The transfer opens with two phases: SCL high with SDA released, then SCL high with SDA pulled low (`sda_oe`=1). Every phase lasts exactly `PHASE_CLKS` clocks.
- R4: The first byte is the slave address, MSB first, followed by a 0 direction bit. Each bit takes one SCL-low phase then one SCL-high phase. `sda_oe` equals the inverse of the bit value, and SDA changes only as SCL goes low.
- R5: After each byte the master sends, SDA is released for one SCL period. The line is sampled in the middle of the SCL-high phase. A low level means acknowledge.
- R6: The second byte is the 8-bit register index, MSB first, with the same bit timing as R4.
- R7: After the register-index acknowledge, a repeated start follows in three phases: SCL low with SDA released, then SCL high with SDA released, then SCL high with SDA pulled low.
- R8: Next comes the slave address, MSB first, with a 1 direction bit and an acknowledge slot. Then eight SCL periods follow with SDA released. The sampled levels form `rd_data` MSB first.
- R9: After the eighth data bit, the master pulls SDA low for one SCL period as its acknowledge. It then sends a stop in three phases: SCL low with SDA low, then SCL high with SDA low, then SCL high with SDA released.
- R10: If any of the three acknowledge slots samples a high level, the stop sequence of R9 begins directly after that slot and `ack_err` reads 1 at completion. `rd_data` keeps its previous value. A successful transfer ends with `ack_err`=0.
- R11: `done` is a one-cycle pulse in the first idle cycle after the stop. `rd_data` and `ack_err` are valid in that cycle. A command presented in that same cycle is accepted.
- R12: Slave address 0x4B and register 0x6D, with a slave that returns 0x49, yield `rd_data`=0x49.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_slave | input | 7 | Slave address of the command |
| cmd_reg | input | 8 | Register index of the command |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | A slave acknowledge was missing |
| rd_data | output | 8 | Byte read by the last successful transfer |
| scl_o | output | 1 | SCL level driven to the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled level of the wired SDA line |

## Verification
The completion pulse of one transfer and the acceptance of the next command can fall in the same cycle. The bench provokes this by raising a new command while a transfer is still running and holding it until the engine returns to idle. The bench expects three things:

- the running waveform stays untouched while the command is held;
- `done` appears with the old result in the first idle cycle;
- the new transfer's start phase follows at the very next edge.

A behavioural model of the expected SCL and SDA phase stream, with a scripted slave, is compared against the pins on every clock.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
    localparam int SLV_W  = 7;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int PH_W   = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_WADDR,
        ST_ACK_A,
        ST_REGB,
        ST_ACK_R,
        ST_RSTART,
        ST_RADDR,
        ST_ACK_B,
        ST_DATA,
        ST_MACK,
        ST_STOP
    } stage_e;

    typedef struct packed {
        stage_e              stage;
        logic [PH_W-1:0]     ph;
        logic [BIT_W-1:0]    bit_idx;
        logic [BYTE_W-1:0]   tx;
        logic [SLV_W-1:0]    slv;
        logic [BYTE_W-1:0]   regb;
        logic [BYTE_W-1:0]   rx;
        logic [BYTE_W-1:0]   rd;
        logic                nack;
        logic                err;
        logic                done;
    } seq_s;

    function automatic logic [PH_W-1:0] last_phase(stage_e s);
        case (s)
            ST_RSTART, ST_STOP: return PH_W'(2);
            default:            return PH_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/i2c_rd_phase_timer.sv
module i2c_rd_phase_timer #(
    parameter int PHASE_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_last,
    output logic phase_mid
);
    localparam int CW = $clog2(PHASE_CLKS);
    localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);
    localparam logic [CW-1:0] MID  = CW'(PHASE_CLKS / 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign phase_last = run && (cnt_q == LAST);
    assign phase_mid  = run && (cnt_q == MID);
endmodule

// File: rtl/i2c_rd_seq.sv
module i2c_rd_seq
    import i2c_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [SLV_W-1:0]  cmd_slave,
    input  logic [BYTE_W-1:0] cmd_reg,
    input  logic              phase_last,
    input  logic              phase_mid,
    input  logic              sda_in,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic              ack_err,
    output logic [BYTE_W-1:0] rd_data,
    output logic              scl,
    output logic              sda_pull
);
    localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(BYTE_W - 1);

    seq_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.stage == ST_IDLE) begin
            if (cmd_valid) begin
                s_d.stage = ST_START;
                s_d.ph    = '0;
                s_d.slv   = cmd_slave;
                s_d.regb  = cmd_reg;
                s_d.err   = 1'b0;
            end
        end else begin
            if (phase_mid && s_q.ph == PH_W'(1)) begin
                case (s_q.stage)
                    ST_ACK_A, ST_ACK_R, ST_ACK_B: s_d.nack = sda_in;
                    ST_DATA: s_d.rx = {s_q.rx[BYTE_W-2:0], sda_in};
                    default: ;
                endcase
            end
            if (phase_last) begin
                if (s_q.ph != last_phase(s_q.stage)) begin
                    s_d.ph = s_q.ph + PH_W'(1);
                end else begin
                    s_d.ph = '0;
                    case (s_q.stage)
                        ST_START: begin
                            s_d.stage   = ST_WADDR;
                            s_d.tx      = {s_q.slv, 1'b0};
                            s_d.bit_idx = MSB_IDX;
                        end
                        ST_WADDR, ST_REGB, ST_RADDR: begin
                            if (s_q.bit_idx == '0) begin
                                s_d.stage = (s_q.stage == ST_WADDR) ? ST_ACK_A :
                                            (s_q.stage == ST_REGB)  ? ST_ACK_R : ST_ACK_B;
                            end else begin
                                s_d.bit_idx = s_q.bit_idx - BIT_W'(1);
                            end
                        end
                        ST_ACK_A, ST_ACK_R, ST_ACK_B: begin
                            if (s_q.nack) begin
                                s_d.err   = 1'b1;
                                s_d.stage = ST_STOP;
                            end else if (s_q.stage == ST_ACK_A) begin
                                s_d.stage   = ST_REGB;
                                s_d.tx      = s_q.regb;
                                s_d.bit_idx = MSB_IDX;
                            end else if (s_q.stage == ST_ACK_R) begin
                                s_d.stage = ST_RSTART;
                            end else begin
                                s_d.stage   = ST_DATA;
                                s_d.bit_idx = MSB_IDX;
                            end
                        end
                        ST_RSTART: begin
                            s_d.stage   = ST_RADDR;
                            s_d.tx      = {s_q.slv, 1'b1};
                            s_d.bit_idx = MSB_IDX;
                        end
                        ST_DATA: begin
                            if (s_q.bit_idx == '0) begin
                                s_d.stage = ST_MACK;
                            end else begin
                                s_d.bit_idx = s_q.bit_idx - BIT_W'(1);
                            end
                        end
                        ST_MACK: begin
                            s_d.stage = ST_STOP;
                            s_d.rd    = s_q.rx;
                        end
                        ST_STOP: begin
                            s_d.stage = ST_IDLE;
                            s_d.done  = 1'b1;
                        end
                        default: s_d.stage = ST_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        scl      = 1'b1;
        sda_pull = 1'b0;
        case (s_q.stage)
            ST_START: sda_pull = (s_q.ph == PH_W'(1));
            ST_WADDR, ST_REGB, ST_RADDR: begin
                scl      = s_q.ph[0];
                sda_pull = ~s_q.tx[s_q.bit_idx];
            end
            ST_ACK_A, ST_ACK_R, ST_ACK_B, ST_DATA: scl = s_q.ph[0];
            ST_MACK: begin
                scl      = s_q.ph[0];
                sda_pull = 1'b1;
            end
            ST_RSTART: begin
                scl      = (s_q.ph != '0);
                sda_pull = (s_q.ph == PH_W'(2));
            end
            ST_STOP: begin
                scl      = (s_q.ph != '0);
                sda_pull = (s_q.ph != PH_W'(2));
            end
            default: ;
        endcase
    end

    assign busy    = (s_q.stage != ST_IDLE);
    assign run     = busy;
    assign done    = s_q.done;
    assign ack_err = s_q.err;
    assign rd_data = s_q.rd;
endmodule

// File: rtl/i2c_ptr_read_master.sv
module i2c_ptr_read_master #(
    parameter int PHASE_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [6:0] cmd_slave,
    input  logic [7:0] cmd_reg,
    output logic       busy,
    output logic       done,
    output logic       ack_err,
    output logic [7:0] rd_data,
    output logic       scl_o,
    output logic       sda_oe,
    input  logic       sda_i
);
    logic run;
    logic phase_last;
    logic phase_mid;

    i2c_rd_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .phase_last (phase_last),
        .phase_mid  (phase_mid)
    );

    i2c_rd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_slave  (cmd_slave),
        .cmd_reg    (cmd_reg),
        .phase_last (phase_last),
        .phase_mid  (phase_mid),
        .sda_in     (sda_i),
        .run        (run),
        .busy       (busy),
        .done       (done),
        .ack_err    (ack_err),
        .rd_data    (rd_data),
        .scl        (scl_o),
        .sda_pull   (sda_oe)
    );
endmodule

// File: rtl/i2c_ptr_read_master_chk.sv
module i2c_ptr_read_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic       scl_o,
    input logic       sda_oe,
    input logic       phase_last,
    input logic [7:0] rd_data
);
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && !sda_oe));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    assert_scl_on_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o != $past(scl_o)) |-> $past(phase_last));

    assert_sda_on_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(phase_last));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(rd_data));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind i2c_ptr_read_master i2c_ptr_read_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .done       (done),
    .scl_o      (scl_o),
    .sda_oe     (sda_oe),
    .phase_last (phase_last),
    .rd_data    (rd_data)
);

// File: tb/i2c_ptr_read_master_bench.sv
module i2c_ptr_read_master_bench;
    localparam int PH = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [6:0] cmd_slave;
    logic [7:0] cmd_reg;
    logic       busy, done, ack_err, scl_o, sda_oe, sda_i;
    logic [7:0] rd_data;
    logic       slave_pull;

    always #2 clk = ~clk;

    assign sda_i = ~(sda_oe | slave_pull);

    i2c_ptr_read_master #(.PHASE_CLKS(PH)) u_i2c_ptr_read_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_slave(cmd_slave),
        .cmd_reg(cmd_reg), .busy(busy), .done(done), .ack_err(ack_err),
        .rd_data(rd_data), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    typedef struct packed { logic scl; logic oe; logic pull; } ph_t;
    ph_t   exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    pend   = 0;
    bit    ended  = 0;
    logic       exp_err  = 1'b0;
    logic [7:0] exp_data = 8'h00;
    string      rd_tag   = "R8";

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(logic s, logic o, logic p, string tag);
        repeat (PH) begin
            exp_q.push_back('{scl: s, oe: o, pull: p});
            tag_q.push_back(tag);
        end
    endtask

    task automatic send_bit(logic b, string tag);
        push(1'b0, ~b, 1'b0, tag);
        push(1'b1, ~b, 1'b0, tag);
    endtask

    task automatic slave_bit(logic level, string tag);
        push(1'b0, 1'b0, ~level, tag);
        push(1'b1, 1'b0, ~level, tag);
    endtask

    task automatic stop_seq();
        push(1'b0, 1'b1, 1'b0, "R9");
        push(1'b1, 1'b1, 1'b0, "R9");
        push(1'b1, 1'b0, 1'b0, "R9");
    endtask

    // nack: 0 none, 1 address-write slot, 2 register slot, 3 address-read slot
    task automatic build(logic [6:0] a, logic [7:0] r, logic [7:0] d, int nack, string dtag);
        push(1'b1, 1'b0, 1'b0, "R3");
        push(1'b1, 1'b1, 1'b0, "R3");
        for (int i = 6; i >= 0; i--) send_bit(a[i], "R4");
        send_bit(1'b0, "R4");
        slave_bit(nack == 1, "R5");
        if (nack == 1) begin stop_seq(); exp_err = 1'b1; rd_tag = "R10"; return; end
        for (int i = 7; i >= 0; i--) send_bit(r[i], "R6");
        slave_bit(nack == 2, "R5");
        if (nack == 2) begin stop_seq(); exp_err = 1'b1; rd_tag = "R10"; return; end
        push(1'b0, 1'b0, 1'b0, "R7");
        push(1'b1, 1'b0, 1'b0, "R7");
        push(1'b1, 1'b1, 1'b0, "R7");
        for (int i = 6; i >= 0; i--) send_bit(a[i], "R8");
        send_bit(1'b1, "R8");
        slave_bit(nack == 3, "R5");
        if (nack == 3) begin stop_seq(); exp_err = 1'b1; rd_tag = "R10"; return; end
        for (int i = 7; i >= 0; i--) slave_bit(d[i], "R8");
        push(1'b0, 1'b1, 1'b0, "R9");
        push(1'b1, 1'b1, 1'b0, "R9");
        stop_seq();
        exp_err  = 1'b0;
        exp_data = d;
        rd_tag   = dtag;
    endtask

    task automatic tick();
        ph_t   e;
        string t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            slave_pull = e.pull;
            chk({t, " scl_o"}, scl_o, e.scl);
            chk({t, " sda_oe"}, sda_oe, e.oe);
            chk("R2 busy high", busy, 1);
            chk("R11 done low while busy", done, 0);
            if (exp_q.size() == 0) pend = 1'b1;
        end else begin
            slave_pull = 1'b0;
            chk("R1 idle scl_o", scl_o, 1);
            chk("R1 idle sda_oe", sda_oe, 0);
            chk("R1 idle busy", busy, 0);
            chk("R11 done pulse", done, pend);
            if (pend) begin
                chk("R10 ack_err", ack_err, exp_err);
                chk({rd_tag, " rd_data"}, rd_data, exp_data);
            end
            pend = 1'b0;
        end
    endtask

    task automatic issue(logic [6:0] a, logic [7:0] r, logic [7:0] d, int nack, string dtag);
        cmd_slave = a;
        cmd_reg   = r;
        cmd_valid = 1'b1;
        build(a, r, d, nack, dtag);
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic finish_txn();
        while (exp_q.size() > 0) tick();
        tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_slave = '0; cmd_reg = '0; slave_pull = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset scl_o", scl_o, 1);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset ack_err", ack_err, 0);
        chk("R1 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        tick(); tick();

        issue(7'h4B, 8'h6D, 8'h49, 0, "R12");
        finish_txn();
        issue(7'h2A, 8'h80, 8'hFF, 0, "R8");
        finish_txn();
        issue(7'h11, 8'h01, 8'h00, 1, "R10");
        finish_txn();
        issue(7'h7F, 8'hC3, 8'h5A, 2, "R10");
        finish_txn();
        issue(7'h00, 8'h3E, 8'h81, 3, "R10");
        finish_txn();
        issue(7'h33, 8'h00, 8'h00, 0, "R8");
        finish_txn();

        // R2 held command ignored while busy, R11 accepted in the done cycle
        issue(7'h55, 8'hA5, 8'h3C, 0, "R8");
        repeat (40) tick();
        cmd_slave = 7'h4B;
        cmd_reg   = 8'h6D;
        cmd_valid = 1'b1;
        while (exp_q.size() > 0) tick();
        tick();
        build(7'h4B, 8'h6D, 8'h96, 0, "R11");
        tick();
        cmd_valid = 1'b0;
        finish_txn();

        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule